// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a small word-addressed cache that sits between a processor-side request port and a simple backing memory. Every set holds two ways. Each way has its own valid bit, tag and data word, and in write-back builds it also has a dirty bit. A request addresses one word. The low address bits pick the set, and the remaining bits form the tag. That tag is compared against both ways of the set at the same moment. A read or write that hits is answered one cycle after it is accepted. A miss parks the request in a small state machine. The state machine may first write a dirty victim back to memory, then fetches the requested word. Then it answers and becomes ready again.

On a miss, an empty way is filled before anything is displaced, and the lowest-numbered empty way is used first. When both ways are full, one recency bit per set names the least recently used way, and that way is replaced. The bit is refreshed by every hit and by every fill. The write policy is chosen at build time. With write-back, write hits only mark the line dirty, and write misses fetch the line and then merge the new word into it. With write-through, every write goes to memory. A write hit also updates the cached copy, and a write miss does not allocate a line.

The processor side is a valid/ready request channel. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The requester holds its fields stable while `req_valid` is high and `req_ready` is low. The response is a single-cycle `rsp_valid` pulse with no back-pressure, so the requester must always take it. The memory side carries one request at a time. The request is held until `mem_ack` arrives. For reads, the data is taken on the `mem_ack` cycle.

Top module: `wsa_cache`

## Requirements
- R1: After reset every way is invalid, every recency bit is clear, `req_ready` is 1, and `rsp_valid` and `mem_valid` are 0. The first access to any word is a miss.
- R2: A read hit raises `rsp_valid` with `rsp_hit`=1 and the stored word one cycle after acceptance, without issuing any memory request.
- R3: The set index is the low log2(SETS) address bits, and the tag is the rest of the address. On a miss, the word is filled into the lowest-numbered invalid way of the set, so two words of one set both stay resident after filling an empty set.
- R4: When both ways of the set are valid, a miss replaces the least recently used way. Every hit and every fill makes its way the most recent. With two sets, words 0,2,0,4,2 give miss,miss,hit,miss,miss, and words 0,2,0,1,4,0,2,3,5,4 give hits only at the third and sixth accesses.
- R5: In write-back mode, a write hit answers one cycle after acceptance with `rsp_hit`=1, updates only the cached word, and leaves memory untouched.
- R6: In write-back mode, a dirty victim is written to memory at its own address with its cached word before the refill read of the requested word is issued.
- R7: In write-back mode, a write miss reads the word from memory, merges the written word into the cache line, and answers with `rsp_hit`=0. Memory keeps its old value until eviction.
- R8: In write-through mode, a write hit updates both the cached word and memory, and answers with `rsp_hit`=1 after the memory write is acknowledged. A later eviction of that line issues no memory write.
- R9: In write-through mode, a write miss writes memory only and answers with `rsp_hit`=0. A following read of that word misses.
- R10: While a miss or memory write is in progress, `req_ready` is 0. Once raised, `mem_valid` stays high with stable address, write enable and write data until `mem_ack`.
- R11: A response with `rsp_data` equal to the written word is returned for writes, and the response is the only `rsp_valid` pulse for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Request was served from the cache |
| rsp_data | output | DATA_W | Read word, or the written word for writes |
| mem_valid | output | 1 | Memory request held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current memory request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The two functions that meet in one request are the write-back of a dirty victim and the write-allocate merge. Both act on the same way during a single write miss. The bench provokes this by dirtying way 0 of a set, making it the least recently used way, and then writing a new word of that set. The bench judges the result from the memory-side transaction log: a write of the old word at the old address must come strictly before the refill read. A later read must then hit with the newly merged word, while memory holds the evicted word and the stale copy of the new address.

// File: rtl/wsa_cache_pkg.sv
package wsa_cache_pkg;

  // Associativity is fixed: the replacement state is a single bit per set.
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // lookup, hits answered here
    ST_EVICT = 2'd1,  // dirty victim going out to memory
    ST_FILL  = 2'd2,  // requested word coming in
    ST_WTHRU = 2'd3   // write-through memory write
  } ctl_state_t;

endpackage

// File: rtl/wsa_tag_match.sv
module wsa_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 7,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);

  logic [WAYS-1:0] match;

  // one comparator per way, all working on the same set at once
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == look_tag);
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/wsa_victim.sv
module wsa_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim
);

  // lowest empty way wins; only a full set falls back to recency
  always_comb begin
    victim = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim = WAY_W'(w);
    end
  end

endmodule

// File: rtl/wsa_cache.sv
module wsa_cache
  import wsa_cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SETS       = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // ---------------- storage ----------------
  logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
  logic [DATA_W-1:0] data_q  [WAYS][SETS];
  logic [SETS-1:0]   valid_q [WAYS];
  logic [SETS-1:0]   dirty_q [WAYS];
  logic [WAY_W-1:0]  lru_q   [SETS];   // names the least recent way

  // ---------------- held request ----------------
  ctl_state_t        state_q;
  logic              q_we;
  logic              q_hit;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [WAY_W-1:0]  q_way;
  logic [IDX_W-1:0]  q_idx;

  assign q_idx = q_addr[IDX_W-1:0];

  // ---------------- lookup ----------------
  logic [IDX_W-1:0]      lk_idx;
  logic [TAG_W-1:0]      lk_tag;
  logic [WAYS-1:0]       set_valid;
  logic [WAYS*TAG_W-1:0] set_tags;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;
  logic [WAY_W-1:0]      vict_way;
  logic                  vict_dirty;

  assign lk_idx = req_addr[IDX_W-1:0];
  assign lk_tag = req_addr[ADDR_W-1:IDX_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w]                 = valid_q[w][lk_idx];
      set_tags[w*TAG_W +: TAG_W]   = tag_q[w][lk_idx];
    end
  end

  wsa_tag_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_match (
    .way_valid(set_valid),
    .way_tags (set_tags),
    .look_tag (lk_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  wsa_victim #(
    .WAYS (WAYS),
    .WAY_W(WAY_W)
  ) u_victim (
    .way_valid(set_valid),
    .lru_way  (lru_q[lk_idx]),
    .victim   (vict_way)
  );

  assign vict_dirty = WRITE_BACK && set_valid[vict_way] && dirty_q[vict_way][lk_idx];

  // ---------------- control strobes ----------------
  logic              accept;
  logic              hit_touch;
  logic              hit_write;
  logic              fill_done;
  logic [DATA_W-1:0] fill_word;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_touch = accept && hit;
  assign hit_write = hit_touch && req_we;
  assign fill_done = (state_q == ST_FILL) && mem_ack;
  assign fill_word = q_we ? q_wdata : mem_rdata;   // write-allocate merge

  // ---------------- state bits with reset ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      if (hit_touch) begin
        lru_q[lk_idx] <= ~hit_way;
        if (hit_write && WRITE_BACK) dirty_q[hit_way][lk_idx] <= 1'b1;
      end
      if (fill_done) begin
        valid_q[q_way][q_idx] <= 1'b1;
        dirty_q[q_way][q_idx] <= WRITE_BACK && q_we;
        lru_q[q_idx]          <= ~q_way;
      end
    end
  end

  // ---------------- tag and data arrays ----------------
  always_ff @(posedge clk) begin
    if (hit_write) data_q[hit_way][lk_idx] <= req_wdata;
    if (fill_done) begin
      tag_q[q_way][q_idx]  <= q_addr[ADDR_W-1:IDX_W];
      data_q[q_way][q_idx] <= fill_word;
    end
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      q_we      <= 1'b0;
      q_hit     <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_way     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            q_we    <= req_we;
            q_hit   <= hit;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_way   <= vict_way;
            if (req_we && !WRITE_BACK) begin
              state_q <= ST_WTHRU;
            end else if (hit) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
              rsp_data  <= req_we ? req_wdata : data_q[hit_way][lk_idx];
            end else if (vict_dirty) begin
              state_q <= ST_EVICT;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_EVICT: if (mem_ack) state_q <= ST_FILL;
        ST_FILL: begin
          if (mem_ack) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_data  <= fill_word;
            state_q   <= ST_IDLE;
          end
        end
        ST_WTHRU: begin
          if (mem_ack) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= q_hit;
            rsp_data  <= q_wdata;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- memory port ----------------
  logic evicting;
  assign evicting  = (state_q == ST_EVICT);
  assign mem_valid = (state_q != ST_IDLE);
  assign mem_we    = evicting || (state_q == ST_WTHRU);
  assign mem_addr  = evicting ? {tag_q[q_way][q_idx], q_idx} : q_addr;
  assign mem_wdata = evicting ? data_q[q_way][q_idx] : q_wdata;

endmodule

// File: rtl/wsa_cache_chk.sv
module wsa_cache_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);

  // R11: a response is caused by an accepted request or a memory acknowledge
  p_rsp_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_ack)));

  // R10: no new request is taken while memory traffic is open
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R10: memory request held steady until acknowledged
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2 / R5: in write-back mode a hit is answered without memory traffic
  p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && rsp_valid && rsp_hit) |-> !$past(mem_valid));

  // R6: an acknowledged eviction is followed by the refill read
  p_evict_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && mem_valid && mem_we && mem_ack) |=> (mem_valid && !mem_we));

  // R8: an acknowledged write-through write completes the request
  p_wt_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && mem_valid && mem_we && mem_ack) |=> rsp_valid);

endmodule

bind wsa_cache wsa_cache_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .mem_valid(mem_valid),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack)
);

// File: tb/tb_wsa_cache.sv
module tb_wsa_mem #(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  logic [31:0] mem    [256];
  logic        lg_we  [256];
  logic [7:0]  lg_addr[256];
  logic [31:0] lg_data[256];
  int lg_n = 0;
  int cnt  = 0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    ack   = 1'b0;
    rdata = '0;
  end

  always @(posedge clk) begin
    ack <= 1'b0;
    if (req && !ack) begin
      if (cnt == LAT - 1) begin
        cnt   <= 0;
        ack   <= 1'b1;
        rdata <= mem[addr];
        if (we) mem[addr] <= wdata;
        lg_we[lg_n % 256]   <= we;
        lg_addr[lg_n % 256] <= addr;
        lg_data[lg_n % 256] <= wdata;
        lg_n <= lg_n + 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module tb_wsa_cache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          sel_wt = 1'b0;
  logic        rq_valid = 1'b0;
  logic        rq_we = 1'b0;
  logic [7:0]  rq_addr = '0;
  logic [31:0] rq_wdata = '0;

  // write-back instance
  logic        b_ready, b_rvalid, b_rhit, b_mvalid, b_mwe, b_mack;
  logic [31:0] b_rdata, b_mwdata, b_mrdata;
  logic [7:0]  b_maddr;
  // write-through instance
  logic        t_ready, t_rvalid, t_rhit, t_mvalid, t_mwe, t_mack;
  logic [31:0] t_rdata, t_mwdata, t_mrdata;
  logic [7:0]  t_maddr;

  wsa_cache dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rq_valid && !sel_wt), .req_ready(b_ready), .req_we(rq_we),
    .req_addr(rq_addr), .req_wdata(rq_wdata),
    .rsp_valid(b_rvalid), .rsp_hit(b_rhit), .rsp_data(b_rdata),
    .mem_valid(b_mvalid), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwdata),
    .mem_ack(b_mack), .mem_rdata(b_mrdata)
  );

  wsa_cache #(.WRITE_BACK(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rq_valid && sel_wt), .req_ready(t_ready), .req_we(rq_we),
    .req_addr(rq_addr), .req_wdata(rq_wdata),
    .rsp_valid(t_rvalid), .rsp_hit(t_rhit), .rsp_data(t_rdata),
    .mem_valid(t_mvalid), .mem_we(t_mwe), .mem_addr(t_maddr), .mem_wdata(t_mwdata),
    .mem_ack(t_mack), .mem_rdata(t_mrdata)
  );

  tb_wsa_mem u_mb (.clk(clk), .req(b_mvalid), .we(b_mwe), .addr(b_maddr), .wdata(b_mwdata),
                   .ack(b_mack), .rdata(b_mrdata));
  tb_wsa_mem u_mt (.clk(clk), .req(t_mvalid), .we(t_mwe), .addr(t_maddr), .wdata(t_mwdata),
                   .ack(t_mack), .rdata(t_mrdata));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int log_n(input bit wt);
    return wt ? u_mt.lg_n : u_mb.lg_n;
  endfunction

  task automatic log_at(input bit wt, input int k, output logic we, output logic [7:0] a,
                        output logic [31:0] d);
    if (wt) begin
      we = u_mt.lg_we[k % 256]; a = u_mt.lg_addr[k % 256]; d = u_mt.lg_data[k % 256];
    end else begin
      we = u_mb.lg_we[k % 256]; a = u_mb.lg_addr[k % 256]; d = u_mb.lg_data[k % 256];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rq_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one request; starts and ends at a falling edge
  task automatic access(input bit wt, input bit we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic hit, output int lat,
                        output int ops, output bit stalled);
    int n0;
    n0 = log_n(wt);
    stalled = 1'b0;
    sel_wt = wt; rq_we = we; rq_addr = a; rq_wdata = d; rq_valid = 1'b1;
    @(posedge clk); #1;
    rq_valid = 1'b0;
    lat = 1;
    while (!(wt ? t_rvalid : b_rvalid) && lat < 100) begin
      if (!(wt ? t_ready : b_ready)) stalled = 1'b1;
      @(posedge clk); #1;
      lat++;
    end
    rd  = wt ? t_rdata : b_rdata;
    hit = wt ? t_rhit : b_rhit;
    ops = log_n(wt) - n0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 ready after reset (wb)", 32'(b_ready), 32'd1);
    chk("R1 no response after reset (wb)", 32'(b_rvalid), 32'd0);
    chk("R1 no memory request after reset (wb)", 32'(b_mvalid), 32'd0);
    chk("R1 ready after reset (wt)", 32'(t_ready), 32'd1);
    chk("R1 no memory request after reset (wt)", 32'(t_mvalid), 32'd0);
  endtask

  task automatic t_conflict_seq();
    logic [7:0] seq [5] = '{8'd0, 8'd2, 8'd0, 8'd4, 8'd2};
    logic exp_hit [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    logic [31:0] rd; logic hit; int lat, ops; bit st;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      access(1'b0, 1'b0, seq[i], '0, rd, hit, lat, ops, st);
      chk($sformatf("R4 conflict seq step %0d hit", i), 32'(hit), 32'(exp_hit[i]));
      chk($sformatf("R2 conflict seq step %0d data", i), rd, 32'hA500_0000 | seq[i]);
      if (exp_hit[i]) begin
        chk("R2 read hit latency", lat, 1);
        chk("R2 read hit no memory traffic", ops, 0);
      end else begin
        chk("R10 ready low during miss", 32'(st), 32'd1);
        if (i == 0) chk("R1 first access misses", 32'(hit), 32'd0);
      end
    end
  endtask

  task automatic t_lru_seq();
    logic [7:0] seq [10] = '{8'd0, 8'd2, 8'd0, 8'd1, 8'd4, 8'd0, 8'd2, 8'd3, 8'd5, 8'd4};
    logic [31:0] rd; logic hit; int lat, ops; bit st; int nhit;
    do_reset();
    nhit = 0;
    for (int i = 0; i < 10; i++) begin
      access(1'b0, 1'b0, seq[i], '0, rd, hit, lat, ops, st);
      chk($sformatf("R4 lru seq step %0d hit", i), 32'(hit), (i == 2 || i == 5) ? 32'd1 : 32'd0);
      if (hit) nhit++;
    end
    chk("R4 lru seq total hits", nhit, 2);
  endtask

  task automatic t_fill_empty();
    logic [31:0] rd; logic hit; int lat, ops; bit st;
    do_reset();
    access(1'b0, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    access(1'b0, 1'b0, 8'd2, '0, rd, hit, lat, ops, st);
    access(1'b0, 1'b0, 8'd2, '0, rd, hit, lat, ops, st);
    chk("R3 second fill resident", 32'(hit), 32'd1);
    access(1'b0, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    chk("R3 first fill kept", 32'(hit), 32'd1);
    chk("R3 first fill data", rd, 32'hA500_0000);
  endtask

  task automatic t_wb_write_and_evict();
    logic [31:0] rd; logic hit; int lat, ops, n0; bit st;
    logic we0, we1; logic [7:0] a0, a1; logic [31:0] d0, d1;
    do_reset();
    access(1'b0, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    access(1'b0, 1'b1, 8'd0, 32'hDEAD_0000, rd, hit, lat, ops, st);
    chk("R5 write hit flag", 32'(hit), 32'd1);
    chk("R5 write hit latency", lat, 1);
    chk("R5 write hit no memory traffic", ops, 0);
    chk("R11 write response data", rd, 32'hDEAD_0000);
    chk("R5 memory untouched", u_mb.mem[0], 32'hA500_0000);
    access(1'b0, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    chk("R5 read back cached word", rd, 32'hDEAD_0000);
    access(1'b0, 1'b0, 8'd2, '0, rd, hit, lat, ops, st);
    n0 = log_n(1'b0);
    access(1'b0, 1'b0, 8'd4, '0, rd, hit, lat, ops, st);
    log_at(1'b0, n0, we0, a0, d0);
    log_at(1'b0, n0 + 1, we1, a1, d1);
    chk("R6 two memory ops for dirty miss", ops, 2);
    chk("R6 first op is write", 32'(we0), 32'd1);
    chk("R6 write-back address", 32'(a0), 32'd0);
    chk("R6 write-back data", d0, 32'hDEAD_0000);
    chk("R6 refill read follows", {31'd0, we1}, 32'd0);
    chk("R6 refill address", 32'(a1), 32'd4);
    chk("R6 refill data", rd, 32'hA500_0004);
    access(1'b0, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    chk("R6 evicted word reread from memory", rd, 32'hDEAD_0000);
  endtask

  task automatic t_wb_alloc_merge();
    logic [31:0] rd; logic hit; int lat, ops, n0; bit st;
    logic we0, we1; logic [7:0] a0, a1; logic [31:0] d0, d1;
    do_reset();
    n0 = log_n(1'b0);
    access(1'b0, 1'b1, 8'd6, 32'hBEEF_0006, rd, hit, lat, ops, st);
    log_at(1'b0, n0, we0, a0, d0);
    chk("R7 write miss flag", 32'(hit), 32'd0);
    chk("R7 write miss fetches", ops, 1);
    chk("R7 fetch is read of word", {we0, 23'd0, a0}, 32'd6);
    access(1'b0, 1'b0, 8'd6, '0, rd, hit, lat, ops, st);
    chk("R7 merged word hits", {hit, 31'd0}, 32'h8000_0000);
    chk("R7 merged word data", rd, 32'hBEEF_0006);
    chk("R7 memory keeps old word", u_mb.mem[6], 32'hA500_0006);
    // dirty victim and merge in one request
    access(1'b0, 1'b0, 8'd8, '0, rd, hit, lat, ops, st);
    n0 = log_n(1'b0);
    access(1'b0, 1'b1, 8'd10, 32'hCAFE_000A, rd, hit, lat, ops, st);
    log_at(1'b0, n0, we0, a0, d0);
    log_at(1'b0, n0 + 1, we1, a1, d1);
    chk("R6 merge miss memory ops", ops, 2);
    chk("R6 eviction before refill", {we0, we1, 22'd0, a0}, {2'b10, 22'd0, 8'd6});
    chk("R6 evicted merge data", d0, 32'hBEEF_0006);
    chk("R7 refill of new word", 32'(a1), 32'd10);
    access(1'b0, 1'b0, 8'd10, '0, rd, hit, lat, ops, st);
    chk("R7 second merge hits", 32'(hit), 32'd1);
    chk("R7 second merge data", rd, 32'hCAFE_000A);
    chk("R7 memory stale for new word", u_mb.mem[10], 32'hA500_000A);
  endtask

  task automatic t_wt_write_hit();
    logic [31:0] rd; logic hit; int lat, ops, n0; bit st;
    logic we0; logic [7:0] a0; logic [31:0] d0;
    do_reset();
    access(1'b1, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    n0 = log_n(1'b1);
    access(1'b1, 1'b1, 8'd0, 32'h1234_0000, rd, hit, lat, ops, st);
    log_at(1'b1, n0, we0, a0, d0);
    chk("R8 write-through hit flag", 32'(hit), 32'd1);
    chk("R8 one memory write", ops, 1);
    chk("R8 memory write fields", {we0, 23'd0, a0}, 32'h8000_0000);
    chk("R8 memory write data", d0, 32'h1234_0000);
    chk("R10 write-through stalls", 32'(st), 32'd1);
    access(1'b1, 1'b0, 8'd0, '0, rd, hit, lat, ops, st);
    chk("R8 cached copy updated", rd, 32'h1234_0000);
    chk("R8 cached copy hits", 32'(hit), 32'd1);
    access(1'b1, 1'b0, 8'd2, '0, rd, hit, lat, ops, st);
    n0 = log_n(1'b1);
    access(1'b1, 1'b0, 8'd4, '0, rd, hit, lat, ops, st);
    log_at(1'b1, n0, we0, a0, d0);
    chk("R8 eviction issues no write", ops, 1);
    chk("R8 only refill read", {we0, 23'd0, a0}, 32'd4);
  endtask

  task automatic t_wt_write_miss();
    logic [31:0] rd; logic hit; int lat, ops, n0; bit st;
    logic we0; logic [7:0] a0; logic [31:0] d0;
    n0 = log_n(1'b1);
    access(1'b1, 1'b1, 8'd12, 32'h5678_000C, rd, hit, lat, ops, st);
    log_at(1'b1, n0, we0, a0, d0);
    chk("R9 write miss flag", 32'(hit), 32'd0);
    chk("R9 write only, no fetch", ops, 1);
    chk("R9 write fields", {we0, 23'd0, a0}, 32'h8000_000C);
    access(1'b1, 1'b0, 8'd12, '0, rd, hit, lat, ops, st);
    chk("R9 no allocation", 32'(hit), 32'd0);
    chk("R9 memory holds written word", rd, 32'h5678_000C);
  endtask

  initial begin
    t_reset_state();
    t_conflict_seq();
    t_lru_seq();
    t_fill_empty();
    t_wb_write_and_evict();
    t_wb_alloc_merge();
    t_wt_write_hit();
    t_wt_write_miss();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule